// File: doc/BRIEF.md
# Command Register Bank for a Frequency-Sweep Engine

This block takes 16-bit command words that an upstream serial receiver has already assembled and hands over as a one-cycle valid strobe with parallel data. The upper four bits of each word pick a destination, and the lower twelve bits carry the value to store. It keeps five configuration registers and drives all of them in parallel to the sweep logic: a control word, an increment count, an interval setting, a 24-bit step and a 24-bit start value.

Each 24-bit register is written in two 12-bit halves. Bit 11 of the control word sets how the halves land. When the bit is clear, each half is written directly by its own command. When the bit is set, a low-half write is held in a private shadow. The later high-half write then updates all 24 bits in one edge, so the downstream logic never sees a mix of old and new halves.

Top module: `sweep_cfg_regs`

## Requirements
- R1: After reset, the control word reads 0x0D3, with bits 7, 6, 4, 1 and 0 set. Every other register reads zero.
- R2: A command with address 0000 stores bits 11:0 into the control word. The value appears one cycle after the strobe.
- R3: A command with address 0001 stores bits 11:0 into the increment count.
- R4: Any command whose bits 15:14 are 01 stores bits 13:0 into the 14-bit interval register.
- R5: Commands with address 10xx, 1110 or 1111 change no register.
- R6: While control bit 11 is 0, each half of a 24-bit register is written alone. Address 0010 writes the step low half, 0011 the step high half, 1100 the start low half and 1101 the start high half. The other half is left unchanged.
- R7: While control bit 11 is 1, a low-half write (0010 or 1100) leaves the visible 24-bit register unchanged.
- R8: While control bit 11 is 1, a high-half write after a pending low half loads both halves in the same cycle. The low half comes from the shadow and the high half from the command.
- R9: While control bit 11 is 1, a high-half write with no pending low half updates the high half and keeps the current low bits.
- R10: A write to the control word discards any pending low half. A later high-half write then keeps the current low bits.
- R11: When the valid strobe is low, no register changes, whatever the command bus carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle strobe marking a command word |
| cmd_word | input | 16 | Command: address in 15:12, payload in 11:0 |
| ctrl_word | output | 12 | Control register contents |
| incr_count | output | 12 | Increment count register |
| intv_val | output | 14 | Increment interval register |
| step_val | output | 24 | Step register |
| start_val | output | 24 | Start register |

## Verification
Most internal faults show up on the outputs one cycle after the offending command, because every register drives a port directly. The shadow half and its pending flag are the exception. They stay hidden until the next high-half write, which then commits a wrong or stale low half. For that reason the bench follows each low-half write with a high-half write, sometimes with a control write or a reserved command in between.

// File: rtl/sweep_cfg_pkg.sv
package sweep_cfg_pkg;

    // Destination picked by the address field of a command.
    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CTRL,
        TGT_COUNT,
        TGT_INTV,
        TGT_WIDE
    } tgt_e;

    // Decoded command: destination, which 24-bit register, which half.
    typedef struct packed {
        tgt_e tgt;
        logic wide_sel;   // 0 = step, 1 = start
        logic hi_half;    // 1 = upper 12 bits
    } dec_t;

endpackage

// File: rtl/sweep_cfg_decode.sv
module sweep_cfg_decode
    import sweep_cfg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        dec = '{tgt: TGT_NONE, wide_sel: 1'b0, hi_half: 1'b0};
        if (valid) begin
            if (addr[ADDR_W-1 -: 2] == 2'b01) begin
                dec.tgt = TGT_INTV;
            end else begin
                case (addr)
                    4'b0000: dec.tgt = TGT_CTRL;
                    4'b0001: dec.tgt = TGT_COUNT;
                    4'b0010,
                    4'b0011: begin
                        dec.tgt      = TGT_WIDE;
                        dec.wide_sel = 1'b0;
                        dec.hi_half  = addr[0];
                    end
                    4'b1100,
                    4'b1101: begin
                        dec.tgt      = TGT_WIDE;
                        dec.wide_sel = 1'b1;
                        dec.hi_half  = addr[0];
                    end
                    default: dec.tgt = TGT_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/sweep_cfg_pair.sv
module sweep_cfg_pair #(
    parameter int HALF_W = 12,
    localparam int FULL_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              hi_sel,
    input  logic              two_write,
    input  logic              clr_pend,
    input  logic [HALF_W-1:0] din,
    output logic [FULL_W-1:0] value
);

    typedef struct packed {
        logic [FULL_W-1:0] val;
        logic [HALF_W-1:0] shadow;
        logic              pend;
    } pair_t;

    pair_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_pend) begin
            s_d.pend = 1'b0;
        end
        if (wr_en) begin
            if (!two_write) begin
                if (hi_sel) s_d.val[FULL_W-1 -: HALF_W] = din;
                else        s_d.val[HALF_W-1:0]         = din;
            end else if (!hi_sel) begin
                s_d.shadow = din;
                s_d.pend   = 1'b1;
            end else begin
                s_d.val  = {din, (s_q.pend ? s_q.shadow : s_q.val[HALF_W-1:0])};
                s_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign value = s_q.val;

endmodule

// File: rtl/sweep_cfg_regs.sv
module sweep_cfg_regs
    import sweep_cfg_pkg::*;
#(
    parameter int CMD_W = 16,
    parameter int ADDR_W = 4,
    parameter logic [CMD_W-ADDR_W-1:0] CTRL_RST = 12'h0D3,
    parameter int MODE_BIT = 11,
    localparam int PAY_W = CMD_W - ADDR_W,
    localparam int INTV_W = CMD_W - 2,
    localparam int WIDE_W = 2 * PAY_W,
    localparam int N_WIDE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic [PAY_W-1:0]  ctrl_word,
    output logic [PAY_W-1:0]  incr_count,
    output logic [INTV_W-1:0] intv_val,
    output logic [WIDE_W-1:0] step_val,
    output logic [WIDE_W-1:0] start_val
);

    typedef struct packed {
        logic [PAY_W-1:0]  ctrl;
        logic [PAY_W-1:0]  count;
        logic [INTV_W-1:0] intv;
    } regs_t;

    regs_t r_d, r_q;
    dec_t  dec;
    logic  [WIDE_W-1:0] wide_val [N_WIDE];

    sweep_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .valid (cmd_valid),
        .addr  (cmd_word[CMD_W-1 -: ADDR_W]),
        .dec   (dec)
    );

    always_comb begin
        r_d = r_q;
        case (dec.tgt)
            TGT_CTRL:  r_d.ctrl  = cmd_word[PAY_W-1:0];
            TGT_COUNT: r_d.count = cmd_word[PAY_W-1:0];
            TGT_INTV:  r_d.intv  = cmd_word[INTV_W-1:0];
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{ctrl: CTRL_RST, count: '0, intv: '0};
        else        r_q <= r_d;
    end

    for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
        sweep_cfg_pair #(.HALF_W(PAY_W)) u_pair (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (dec.tgt == TGT_WIDE && dec.wide_sel == 1'(g)),
            .hi_sel    (dec.hi_half),
            .two_write (r_q.ctrl[MODE_BIT]),
            .clr_pend  (dec.tgt == TGT_CTRL),
            .din       (cmd_word[PAY_W-1:0]),
            .value     (wide_val[g])
        );
    end

    assign ctrl_word  = r_q.ctrl;
    assign incr_count = r_q.count;
    assign intv_val   = r_q.intv;
    assign step_val   = wide_val[0];
    assign start_val  = wide_val[1];

endmodule

// File: rtl/sweep_cfg_regs_chk.sv
module sweep_cfg_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [15:0] cmd_word,
    input logic [11:0] ctrl_word,
    input logic [11:0] incr_count,
    input logic [13:0] intv_val,
    input logic [23:0] step_val,
    input logic [23:0] start_val
);

    logic [3:0] a;
    logic [85:0] all_out;
    assign a = cmd_word[15:12];
    assign all_out = {ctrl_word, incr_count, intv_val, step_val, start_val};

    p_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && a == 4'b0000 |=> ctrl_word == $past(cmd_word[11:0]));

    p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && a == 4'b0001 |=> incr_count == $past(cmd_word[11:0]));

    p_intv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && a[3:2] == 2'b01 |=> intv_val == $past(cmd_word[13:0]));

    p_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (a[3:2] == 2'b10 || a[3:1] == 3'b111) |=> $stable(all_out));

    p_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !ctrl_word[11] && a == 4'b0010
        |=> step_val[11:0] == $past(cmd_word[11:0]) && $stable(step_val[23:12]));

    p_lowhold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && ctrl_word[11] && (a == 4'b0010 || a == 4'b1100)
        |=> $stable(step_val) && $stable(start_val));

    p_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && ctrl_word[11] && a == 4'b1101
        |=> start_val[23:12] == $past(cmd_word[11:0]));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(all_out));

endmodule

bind sweep_cfg_regs sweep_cfg_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_word   (cmd_word),
    .ctrl_word  (ctrl_word),
    .incr_count (incr_count),
    .intv_val   (intv_val),
    .step_val   (step_val),
    .start_val  (start_val)
);

// File: tb/sweep_cfg_regs_test.sv
`timescale 1ns/1ps
module sweep_cfg_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [11:0] ctrl_word, incr_count;
    logic [13:0] intv_val;
    logic [23:0] step_val, start_val;

    int checks = 0;
    int errors = 0;

    // Reference state, updated from the requirements.
    logic [11:0] m_ctrl = 12'h0D3;
    logic [11:0] m_cnt = '0;
    logic [13:0] m_intv = '0;
    logic [23:0] m_wide [2];
    logic [11:0] m_sh [2];
    logic        m_pend [2];

    always #4 clk = ~clk;

    sweep_cfg_regs uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .ctrl_word(ctrl_word), .incr_count(incr_count), .intv_val(intv_val),
        .step_val(step_val), .start_val(start_val)
    );

    task automatic check(input string tag);
        logic [85:0] act, exp;
        act = {ctrl_word, incr_count, intv_val, step_val, start_val};
        exp = {m_ctrl, m_cnt, m_intv, m_wide[0], m_wide[1]};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Applies one command to the reference and returns the requirement it exercises.
    function automatic string model(input logic [15:0] w);
        logic [3:0]  a = w[15:12];
        logic [11:0] p = w[11:0];
        int          s;
        string       tag;
        if (a[3:2] == 2'b01) begin
            m_intv = w[13:0];
            return "R4";
        end
        case (a)
            4'h0: begin
                m_ctrl = p; m_pend[0] = 1'b0; m_pend[1] = 1'b0;
                return "R2";
            end
            4'h1: begin m_cnt = p; return "R3"; end
            4'h2, 4'h3, 4'hC, 4'hD: begin
                s = (a[3]) ? 1 : 0;
                if (!m_ctrl[11]) begin
                    if (a[0]) m_wide[s][23:12] = p; else m_wide[s][11:0] = p;
                    tag = "R6";
                end else if (!a[0]) begin
                    m_sh[s] = p; m_pend[s] = 1'b1;
                    tag = "R7";
                end else begin
                    tag = m_pend[s] ? "R8" : "R9";
                    m_wide[s] = {p, (m_pend[s] ? m_sh[s] : m_wide[s][11:0])};
                    m_pend[s] = 1'b0;
                end
                return tag;
            end
            default: return "R5";
        endcase
    endfunction

    task automatic send(input logic [15:0] w, input string extra = "");
        string tag;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = ~w;
        tag = model(w);
        check({tag, extra});
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_wide[0] = '0; m_wide[1] = '0;
        m_sh[0] = '0; m_sh[1] = '0;
        m_pend[0] = 1'b0; m_pend[1] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset values");

        // R11: garbage on the bus without the strobe.
        for (int i = 0; i < 16; i++) begin
            cmd_word = 16'(i * 16'h1111) ^ 16'h5A3C;
            @(negedge clk);
            check("R11 idle bus");
        end

        // Sweep every address in both write modes.
        for (int mode = 0; mode < 2; mode++) begin
            send({4'h0, 1'(mode), 11'h0D3});
            for (int round = 0; round < 2; round++) begin
                for (int a = 1; a < 16; a++) begin
                    send({4'(a), (12'(a * 12'h123) + 12'(round * 12'h351)) ^ 12'hA5C});
                end
            end
        end

        // R9: high write straight after entering two-write mode.
        send(16'h08D3);
        send(16'h3ABC, " high-only");
        // R10: control write drops the pending low half.
        send(16'hC777, " low pending");
        send(16'h08D3, " clears pending");
        send(16'hD888, " R10 high after clear");
        // Pending survives unrelated and reserved commands.
        send(16'h2246);
        send(16'h9FFF);
        send(16'h1055);
        send(16'h3913, " commit after gap");
        // Back to split mode: halves independent again.
        send(16'h00D3);
        send(16'hD0F0);
        send(16'hC00F);
        send(16'hFFFF);
        send(16'hE123);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule